// File: doc/BRIEF.md
# Exception and Interrupt Control Register Unit

This block holds the three system-control registers a 32-bit processor core needs to take and leave exceptions: a processor-state register (interrupt mask, exception-level flag, global interrupt enable, a constant user-mode flag), an exception-reason register (branch-delay flag, latched interrupt requests, exception code) and an exception return-address register. The core reads and writes them by register number through a move-from / move-to port. On its side, the core gets a combinational interrupt-take request, the fixed handler vector and the return address.

When the core's control logic enters an exception, it pulses an entry strobe. With the strobe it gives the exception code, the address of the affected instruction and a branch-delay flag. The unit latches the code and flag and sets the exception-level flag, which blocks any further interrupt. It also stores the return address. For an external interrupt, that is the address of the following instruction. For a trap, it is the address of the faulting instruction. A return strobe clears only the exception-level flag, and the core then jumps to the stored return address.

Eight request lines set the latched pending bits on the next clock edge, whatever the enable and mask settings. Those bits stay set until software clears them. The reset input is asserted asynchronously and released through a two-stage synchronizer, so internal state leaves reset two clock edges after the input rises.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, register 12 reads 0x00000010, registers 13 and 14 read 0, `irq_take` is 0 and `ret_addr` is 0.
- R2: A write to register 12 loads the mask (bits 15:8), exception level (bit 1) and interrupt enable (bit 0). Bit 4 always reads 1 and every other bit reads 0.
- R3: A write to register 13 affects only the pending field (bits 15:8). The branch-delay bit 31 and the code field 6:2 ignore writes, and all other bits read 0.
- R4: A high level on request line i sets Cause bit 8+i at the next edge, even with interrupt enable 0 and mask 0. The bit stays set after the line drops, until software writes it to 0.
- R5: While request line i is high, a software write of 0 to Cause bit 8+i has no effect.
- R6: `irq_take` is 1 exactly when interrupt enable is 1, exception level is 0 and some pending bit has its mask bit set.
- R7: An entry strobe sets exception level to 1. It stores the 5-bit code in Cause 6:2 and the branch-delay flag in Cause 31. Interrupt enable and mask stay unchanged.
- R8: On entry with code 0 (external interrupt), the return address becomes the victim address plus 4. For any nonzero code (for example 4, 5, 6, 7, 8, 9, 10, 12), it becomes the victim address itself.
- R9: A return strobe clears exception level only, and `ret_addr` always shows register 14.
- R10: `handler_vec` is constantly 0x80000180.
- R11: Register 14 is fully read/write. Every register number other than 12, 13 and 14 reads 0.
- R12: In a cycle with an entry strobe, the entry result wins over a same-cycle software write to register 12 or 14 and over a same-cycle return strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exc_enter | input | 1 | Exception entry strobe |
| exc_code | input | 5 | Exception code to record |
| exc_bd | input | 1 | Victim instruction sits in a branch-delay slot |
| victim_pc | input | 32 | Address of the instruction at which the exception occurs |
| exc_return | input | 1 | Return-from-exception strobe |
| irq_req | input | 8 | Interrupt request lines (0,1 software; 2..7 hardware) |
| wr_en | input | 1 | Move-to write strobe |
| wr_num | input | 5 | Register number for the write |
| wr_data | input | 32 | Write data |
| rd_num | input | 5 | Register number for the read |
| rd_data | output | 32 | Read data (combinational) |
| irq_take | output | 1 | Interrupt should be taken now |
| handler_vec | output | 32 | Handler entry address |
| ret_addr | output | 32 | Return address for the exception return |

## Verification
The assertions assume that the core pulses the entry strobe for single cycles and only with the defined code values. They also assume that software never writes register 13 in the same cycle as an entry that it expects to be recorded. The stimulus drives every strobe for exactly one cycle on the falling edge and walks through the whole code list with both branch-delay values. It also keeps the request lines low whenever a pending field is compared with a value written by software, except in the deliberate live-request cases.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // processor-state field positions
  localparam int unsigned ST_IE_BIT  = 0;
  localparam int unsigned ST_EXL_BIT = 1;
  localparam int unsigned ST_UM_BIT  = 4;
  // shared position of mask (state) and pending (reason) fields
  localparam int unsigned IRQ_LO     = 8;
  // exception-reason field positions
  localparam int unsigned CA_CODE_LO = 2;
  localparam int unsigned CA_CODE_W  = 5;
  localparam int unsigned CA_BD_BIT  = 31;

  localparam logic [4:0] RN_BADADDR = 5'd8;
  localparam logic [4:0] RN_COUNT   = 5'd9;
  localparam logic [4:0] RN_COMPARE = 5'd11;
  localparam logic [4:0] RN_STATE   = 5'd12;
  localparam logic [4:0] RN_REASON  = 5'd13;
  localparam logic [4:0] RN_RETPC   = 5'd14;

  typedef enum logic [4:0] {
    EC_INTR   = 5'd0,
    EC_ADR_LD = 5'd4,
    EC_ADR_ST = 5'd5,
    EC_BUS_I  = 5'd6,
    EC_BUS_D  = 5'd7,
    EC_SYSC   = 5'd8,
    EC_BRKP   = 5'd9,
    EC_RSVD   = 5'd10,
    EC_OVFL   = 5'd12
  } exc_code_e;
endpackage

// File: rtl/exc_state_reg.sv
module exc_state_reg #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_IRQ-1:0] wr_mask,
  input  logic               wr_exl,
  input  logic               wr_ie,
  input  logic               exc_enter,
  input  logic               exc_return,
  output logic [NUM_IRQ-1:0] mask_q,
  output logic               exl_q,
  output logic               ie_q
);
  logic [NUM_IRQ-1:0] mask_d;
  logic               exl_d;
  logic               ie_d;
  logic               upd_en;

  assign upd_en = exc_enter | wr_en | exc_return;

  always_comb begin
    mask_d = mask_q;
    exl_d  = exl_q;
    ie_d   = ie_q;
    if (exc_enter) begin
      exl_d = 1'b1;
    end else begin
      if (wr_en) begin
        mask_d = wr_mask;
        exl_d  = wr_exl;
        ie_d   = wr_ie;
      end
      if (exc_return) exl_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      exl_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else if (upd_en) begin
      mask_q <= mask_d;
      exl_q  <= exl_d;
      ie_q   <= ie_d;
    end
  end

  // R7
  entry_sets_exl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> (exl_q && ie_q == $past(ie_q) && mask_q == $past(mask_q)));
  // R9
  return_clears_exl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_enter) |=> !exl_q);
endmodule

// File: rtl/exc_reason_reg.sv
module exc_reason_reg #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned CODE_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_IRQ-1:0] wr_pend,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               exc_enter,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic               exc_bd,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [CODE_W-1:0]  code_q,
  output logic               bd_q
);
  logic [NUM_IRQ-1:0] pend_d;
  logic [CODE_W-1:0]  code_d;
  logic               bd_d;

  // live request lines always win over the software value
  always_comb begin
    pend_d = irq_req | (wr_en ? wr_pend : pend_q);
    code_d = exc_enter ? exc_code : code_q;
    bd_d   = exc_enter ? exc_bd   : bd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      code_q <= '0;
      bd_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (exc_enter) begin
        code_q <= code_d;
        bd_q   <= bd_d;
      end
    end
  end

  // R4
  req_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |=> ((pend_q & $past(irq_req)) == $past(irq_req)));
  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_enter |=> (code_q == $past(code_q) && bd_q == $past(bd_q)));
endmodule

// File: rtl/exc_retpc_reg.sv
module exc_retpc_reg #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CODE_W  = 5,
  parameter int unsigned INSN_SZ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              exc_enter,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [ADDR_W-1:0] victim_pc,
  output logic [ADDR_W-1:0] epc_q
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_SZ);

  logic [ADDR_W-1:0] epc_d;
  logic              is_intr;

  assign is_intr = (exc_code == exc_pkg::EC_INTR);

  always_comb begin
    epc_d = epc_q;
    if (exc_enter)  epc_d = is_intr ? (victim_pc + STEP) : victim_pc;
    else if (wr_en) epc_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                epc_q <= '0;
    else if (exc_enter | wr_en) epc_q <= epc_d;
  end

  // R8
  intr_next_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter && exc_code == '0) |=> (epc_q == $past(victim_pc) + STEP));
  // R8
  trap_same_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter && exc_code != '0) |=> (epc_q == $past(victim_pc)));
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit #(
  parameter int unsigned       NUM_IRQ   = 8,
  parameter int unsigned       INSN_SZ   = 4,
  parameter logic [31:0]       VEC_ADDR  = 32'h8000_0180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_enter,
  input  logic [4:0]         exc_code,
  input  logic               exc_bd,
  input  logic [31:0]        victim_pc,
  input  logic               exc_return,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               wr_en,
  input  logic [4:0]         wr_num,
  input  logic [31:0]        wr_data,
  input  logic [4:0]         rd_num,
  output logic [31:0]        rd_data,
  output logic               irq_take,
  output logic [31:0]        handler_vec,
  output logic [31:0]        ret_addr
);
  import exc_pkg::*;

  localparam int unsigned IRQ_HI = IRQ_LO + NUM_IRQ - 1;
  localparam int unsigned CODE_HI = CA_CODE_LO + CA_CODE_W - 1;

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic                wr_state, wr_reason, wr_retpc;
  logic [NUM_IRQ-1:0]  mask_q, pend_q;
  logic                exl_q, ie_q, bd_q;
  logic [CA_CODE_W-1:0] code_q;
  logic [31:0]         epc_q;
  logic [31:0]         state_word, reason_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_state  = wr_en && (wr_num == RN_STATE);
  assign wr_reason = wr_en && (wr_num == RN_REASON);
  assign wr_retpc  = wr_en && (wr_num == RN_RETPC);

  exc_state_reg #(.NUM_IRQ(NUM_IRQ)) u_state (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_state),
    .wr_mask(wr_data[IRQ_HI:IRQ_LO]), .wr_exl(wr_data[ST_EXL_BIT]),
    .wr_ie(wr_data[ST_IE_BIT]), .exc_enter(exc_enter), .exc_return(exc_return),
    .mask_q(mask_q), .exl_q(exl_q), .ie_q(ie_q)
  );

  exc_reason_reg #(.NUM_IRQ(NUM_IRQ), .CODE_W(CA_CODE_W)) u_reason (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_reason),
    .wr_pend(wr_data[IRQ_HI:IRQ_LO]), .irq_req(irq_req),
    .exc_enter(exc_enter), .exc_code(exc_code), .exc_bd(exc_bd),
    .pend_q(pend_q), .code_q(code_q), .bd_q(bd_q)
  );

  exc_retpc_reg #(.ADDR_W(32), .CODE_W(CA_CODE_W), .INSN_SZ(INSN_SZ)) u_retpc (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_retpc), .wr_data(wr_data),
    .exc_enter(exc_enter), .exc_code(exc_code), .victim_pc(victim_pc),
    .epc_q(epc_q)
  );

  always_comb begin
    state_word                    = '0;
    state_word[IRQ_HI:IRQ_LO]     = mask_q;
    state_word[ST_UM_BIT]         = 1'b1;
    state_word[ST_EXL_BIT]        = exl_q;
    state_word[ST_IE_BIT]         = ie_q;
    reason_word                   = '0;
    reason_word[CA_BD_BIT]        = bd_q;
    reason_word[IRQ_HI:IRQ_LO]    = pend_q;
    reason_word[CODE_HI:CA_CODE_LO] = code_q;
  end

  always_comb begin
    case (rd_num)
      RN_STATE:  rd_data = state_word;
      RN_REASON: rd_data = reason_word;
      RN_RETPC:  rd_data = epc_q;
      default:   rd_data = '0;
    endcase
  end

  assign irq_take    = ie_q & ~exl_q & (|(pend_q & mask_q));
  assign handler_vec = VEC_ADDR;
  assign ret_addr    = epc_q;

  // R6
  no_take_in_handler_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(exc_enter) |-> !irq_take);
endmodule

// File: tb/exc_ctrl_unit_bench.sv
`timescale 1ns/1ps
module exc_ctrl_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_enter, exc_bd, exc_return, wr_en;
  logic [4:0]  exc_code, wr_num, rd_num;
  logic [31:0] victim_pc, wr_data, rd_data, handler_vec, ret_addr;
  logic [7:0]  irq_req;
  logic        irq_take;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  exc_ctrl_unit u_exc_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .exc_enter(exc_enter), .exc_code(exc_code),
    .exc_bd(exc_bd), .victim_pc(victim_pc), .exc_return(exc_return),
    .irq_req(irq_req), .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .rd_num(rd_num), .rd_data(rd_data), .irq_take(irq_take),
    .handler_vec(handler_vec), .ret_addr(ret_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] n, input logic [31:0] d);
    wr_en = 1'b1; wr_num = n; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n, output logic [31:0] d);
    rd_num = n;
    #1;
    d = rd_data;
  endtask

  task automatic enter(input logic [4:0] c, input logic b, input logic [31:0] pc);
    exc_enter = 1'b1; exc_code = c; exc_bd = b; victim_pc = pc;
    @(negedge clk);
    exc_enter = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [4:0]  codes [9];
    codes = '{5'd0, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd12};
    rst_n = 1'b0; exc_enter = 0; exc_bd = 0; exc_return = 0; wr_en = 0;
    exc_code = 0; wr_num = 0; rd_num = 0; victim_pc = 0; wr_data = 0; irq_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, R10 vector
    rd(5'd12, v); chk("R1 state", v, 32'h10);
    rd(5'd13, v); chk("R1 reason", v, 0);
    rd(5'd14, v); chk("R1 retpc", v, 0);
    chk("R1 irq_take", {31'd0, irq_take}, 0);
    chk("R1 ret_addr", ret_addr, 0);
    chk("R10 vector", handler_vec, 32'h8000_0180);

    // R2 single-bit sweep of the state register
    for (int k = 0; k < 32; k++) begin
      wr(5'd12, 32'h1 << k);
      rd(5'd12, v); chk("R2 bit", v, ((32'h1 << k) & 32'h0000_FF03) | 32'h10);
    end
    wr(5'd12, 32'hFFFF_FFFF); rd(5'd12, v); chk("R2 ones", v, 32'h0000_FF13);
    wr(5'd12, 32'h0);         rd(5'd12, v); chk("R2 zero", v, 32'h10);

    // R3 reason register: only pending writable
    wr(5'd13, 32'hFFFF_FFFF); rd(5'd13, v); chk("R3 ones", v, 32'h0000_FF00);
    wr(5'd13, 32'h8000_007C); rd(5'd13, v); chk("R3 ro fields", v, 32'h0);

    // R11 register map and full retpc access
    wr(5'd14, 32'h1234_5679); rd(5'd14, v); chk("R11 retpc rw", v, 32'h1234_5679);
    chk("R9 ret_addr", ret_addr, 32'h1234_5679);
    wr(5'd12, 32'h0000_FF03); wr(5'd13, 32'h0000_FF00);
    for (int n = 0; n < 32; n++) begin
      if (n != 12 && n != 13 && n != 14) begin
        rd(5'(n), v); chk("R11 unmapped", v, 0);
      end
    end
    wr(5'd12, 32'h0); wr(5'd13, 32'h0);

    // R4 pending capture while disabled and masked
    for (int i = 0; i < 8; i++) begin
      irq_req = 8'h1 << i; @(negedge clk); irq_req = 0;
      @(negedge clk);
      rd(5'd13, v); chk("R4 latched", v, 32'h100 << i);
      chk("R4 no take", {31'd0, irq_take}, 0);
      wr(5'd13, 32'h0); rd(5'd13, v); chk("R4 cleared", v, 0);
    end

    // R5 live request overrides software clear
    for (int i = 0; i < 8; i++) begin
      irq_req = 8'h1 << i; @(negedge clk);
      wr(5'd13, 32'h0); rd(5'd13, v); chk("R5 live", v, 32'h100 << i);
      irq_req = 0; @(negedge clk);
      wr(5'd13, 32'h0); rd(5'd13, v); chk("R5 released", v, 0);
    end

    // R6 exhaustive take decision per level
    for (int i = 0; i < 8; i++) begin
      for (int c = 0; c < 16; c++) begin
        logic ie, exl, m, p;
        {ie, exl, m, p} = 4'(c);
        wr(5'd12, (32'(m) << (8 + i)) | (32'(exl) << 1) | 32'(ie));
        wr(5'd13, 32'(p) << (8 + i));
        chk("R6 take", {31'd0, irq_take}, {31'd0, ie & ~exl & m & p});
      end
    end
    wr(5'd13, 32'h0);

    // R7 / R8 / R9 entry and return for every code
    for (int b = 0; b < 2; b++) begin
      for (int j = 0; j < 9; j++) begin
        logic [31:0] pc;
        pc = 32'h0040_0000 + 32'(j * 16 + b * 256);
        wr(5'd12, 32'h0000_AB01);
        wr(5'd13, 32'h0000_0100);
        enter(codes[j], b[0], pc);
        rd(5'd12, v); chk("R7 state", v, 32'h0000_AB13);
        rd(5'd13, v); chk("R7 reason", v, (32'(b) << 31) | 32'h100 | (32'(codes[j]) << 2));
        chk("R7 no take", {31'd0, irq_take}, 0);
        chk("R8 retaddr", ret_addr, (codes[j] == 0) ? pc + 4 : pc);
        exc_return = 1'b1; @(negedge clk); exc_return = 1'b0;
        rd(5'd12, v); chk("R9 state", v, 32'h0000_AB11);
        chk("R9 retaddr", ret_addr, (codes[j] == 0) ? pc + 4 : pc);
        chk("R9 take", {31'd0, irq_take}, 1);
        wr(5'd13, 32'h0);
      end
    end

    // R12 entry beats same-cycle writes and return
    wr(5'd12, 32'h0000_0301);
    wr_en = 1'b1; wr_num = 5'd12; wr_data = 32'hFFFF_FFFF; exc_return = 1'b1;
    enter(5'd8, 1'b0, 32'h0000_2000);
    wr_en = 1'b0; exc_return = 1'b0;
    rd(5'd12, v); chk("R12 state", v, 32'h0000_0313);
    wr_en = 1'b1; wr_num = 5'd14; wr_data = 32'hDEAD_BEE0;
    enter(5'd0, 1'b0, 32'h0000_3000);
    wr_en = 1'b0;
    rd(5'd14, v); chk("R12 retpc", v, 32'h0000_3004);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule